// File: doc/BRIEF.md
# Power-Line Home-Control Frame Transmitter

This block sends one home-control command through a power-line carrier modem. Bits are not timed by a local baud counter. Each half cycle of the mains carries one symbol, and a symbol of 1 is a carrier-enable pulse of fixed length that starts at a zero crossing. A command holds a house index (0..15), a key index (0..31, where 0..15 are unit numbers and 16..31 are functions) and a repeat count. It arrives on a valid/ready handshake. A synchronised copy of the modem's zero-crossing square wave paces the transmission, and every rising or falling edge of that wave counts as a crossing.

After a command is accepted, the block first locks onto a crossing. It then stays silent through a gap of crossings and sends the 22-symbol frame as many times as requested, with no pause between copies. Each frame is a raw start pattern, then the house field and then the key field. Every house and key bit goes out as a true/complement pair. A watchdog aborts the command with an error pulse when the crossings stop. Commands whose indices are out of range are refused with an error pulse. A repeat count of zero completes at once with a done pulse.

The controller has seven states. IDLE accepts a command. It moves to FAIL when the indices are bad, to DONE when the repeat count is zero, and to SYNC otherwise. SYNC moves to GAP on the first crossing. GAP moves to SEND on the last of its silent crossings. SEND launches one symbol per crossing and moves to TAIL when it launches the final symbol of the final copy. TAIL moves to DONE once that symbol's pulse window has closed. SYNC, GAP and SEND all move to FAIL when the watchdog expires. DONE and FAIL each last one cycle and return to IDLE.

Top module: `plc_frame_tx`

## Requirements
- R1: While reset is held and in the first idle cycle after reset, carrier_en, tx_done and tx_err are 0 and cmd_ready is 1.
- R2: cmd_ready is 1 only in IDLE. A command is taken on a rising clock edge where both cmd_valid and cmd_ready are 1, and cmd_ready is 0 in the cycle after that edge.
- R3: A command with cmd_house >= 16 or cmd_key >= 32 produces a one-cycle tx_err in the cycle after acceptance and no carrier.
- R4: A valid command with cmd_reps = 0 produces a one-cycle tx_done in the cycle after acceptance and no carrier.
- R5: Counting crossings after acceptance, the first one is the sync crossing and the next GAP_XINGS-1 are silent. Symbol 0 of the first frame is launched on crossing number GAP_XINGS after the sync crossing (the 6th by default). A crossing is acted on at the second rising clock edge after the edge that first samples the new zc_in level.
- R6: A launched symbol of 1 drives carrier_en high for exactly PULSE_US*CYC_PER_US cycles, starting in the cycle after the launching edge. A symbol of 0 keeps carrier_en low.
- R7: A frame is 22 symbols, launched in this order: 1,1,1,0, then 4 house pairs, then 5 key pairs. Each pair is the bit followed by its complement, most significant bit first. Every frame therefore holds exactly 12 ones.
- R8: House indices 0..15 map to these 4-bit codes, written in sending order: 0110, 1110, 0010, 1010, 0001, 1001, 0101, 1101, 0111, 1111, 0011, 1011, 0000, 1000, 0100, 1100.
- R9: The 5-bit key code is the house code of the index followed by a 0 for key indices 0..15. For key indices 16..31 it is the binary value of (index-16), most significant bit first, followed by a 1.
- R10: Each copy of the frame starts on the crossing right after the last symbol of the copy before it, so the repeat count is sent back to back.
- R11: tx_done pulses for one cycle, PULSE_US*CYC_PER_US+1 cycles after the edge that launched the last symbol. tx_done and tx_err are never high together.
- R12: In SYNC, GAP or SEND, if WDOG_HALVES*HALF_US*CYC_PER_US+1 cycles pass after acceptance or after the last crossing with no new crossing, tx_err pulses for one cycle, carrier_en is 0 and the block returns to IDLE.
- R13: Rising and falling edges of zc_in count as crossings alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and taking a command |
| cmd_house | input | IDX_W | House index, valid range 0..15 |
| cmd_key | input | IDX_W | Unit/function index, valid range 0..31 |
| cmd_reps | input | REP_W | Number of back-to-back frame copies |
| zc_in | input | 1 | Mains zero-crossing square wave, asynchronous |
| carrier_en | output | 1 | Carrier enable to the modem |
| tx_done | output | 1 | One-cycle pulse: command finished |
| tx_err | output | 1 | One-cycle pulse: command refused or aborted |

## Verification
The hardest case to reach is an abort partway through a frame. The watchdog must expire while a multi-copy send is running, after some symbols have been launched, with no other event on the same edge. The bench stops its crossing generator several hundred cycles into a send and lets the reference model predict the exact cycle of the error pulse. It then restarts the wave and sends a further command to show the block recovers. A second abort case stops the wave before acceptance, so the watchdog fires while the block is still waiting for the sync crossing.

// File: rtl/plc_frame_pkg.sv
`timescale 1ns/1ps
package plc_frame_pkg;

    localparam int FRAME_LEN  = 22;
    localparam int HOUSE_BITS = 4;
    localparam int KEY_BITS   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_GAP,
        ST_SEND,
        ST_TAIL,
        ST_DONE,
        ST_FAIL
    } tx_state_e;

    // House codes for indices 0..15, index 0 in the top nibble, sending order MSB first
    localparam logic [63:0] HOUSE_TBL = {
        4'b0110, 4'b1110, 4'b0010, 4'b1010,
        4'b0001, 4'b1001, 4'b0101, 4'b1101,
        4'b0111, 4'b1111, 4'b0011, 4'b1011,
        4'b0000, 4'b1000, 4'b0100, 4'b1100
    };

    function automatic logic [HOUSE_BITS-1:0] house_nibble(input logic [HOUSE_BITS-1:0] idx);
        return HOUSE_TBL[{~idx, 2'b00} +: HOUSE_BITS];
    endfunction

    function automatic logic [KEY_BITS-1:0] key_code(input logic [KEY_BITS-1:0] idx);
        return idx[KEY_BITS-1] ? {idx[KEY_BITS-2:0], 1'b1}
                               : {house_nibble(idx[KEY_BITS-2:0]), 1'b0};
    endfunction

endpackage

// File: rtl/plc_zc_edge.sv
`timescale 1ns/1ps
module plc_zc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_raw,
    output logic crossing
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], zc_raw};
    end

    // either polarity of change in the synchronised level is a crossing
    assign crossing = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/plc_frame_build.sv
`timescale 1ns/1ps
module plc_frame_build
    import plc_frame_pkg::*;
(
    input  logic [HOUSE_BITS-1:0] house,
    input  logic [KEY_BITS-1:0]   key,
    output logic [FRAME_LEN-1:0]  frame
);
    localparam int HOUSE_TOP = FRAME_LEN - 5;
    localparam int KEY_TOP   = 2*KEY_BITS - 1;

    logic [HOUSE_BITS-1:0] hn;
    logic [KEY_BITS-1:0]   kc;

    assign hn = house_nibble(house);
    assign kc = key_code(key);
    assign frame[FRAME_LEN-1 -: 4] = 4'b1110;

    for (genvar i = 0; i < HOUSE_BITS; i++) begin : g_house
        assign frame[HOUSE_TOP - 2*i]     =  hn[HOUSE_BITS-1-i];
        assign frame[HOUSE_TOP - 2*i - 1] = ~hn[HOUSE_BITS-1-i];
    end

    for (genvar i = 0; i < KEY_BITS; i++) begin : g_key
        assign frame[KEY_TOP - 2*i]     =  kc[KEY_BITS-1-i];
        assign frame[KEY_TOP - 2*i - 1] = ~kc[KEY_BITS-1-i];
    end
endmodule

// File: rtl/plc_pulse_timer.sv
`timescale 1ns/1ps
module plc_pulse_timer #(
    parameter int WIDTH_CYC = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(WIDTH_CYC + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
        end else if (start) begin
            active <= 1'b1;
            left   <= CW'(WIDTH_CYC - 1);
        end else if (active) begin
            if (left == '0) active <= 1'b0;
            else            left   <= left - 1'b1;
        end
    end
endmodule

// File: rtl/plc_watchdog.sv
`timescale 1ns/1ps
module plc_watchdog #(
    parameter int LIMIT = 31248750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || kick) quiet <= '0;
        else                           quiet <= quiet + 1'b1;
    end

    assign expired = enable && (quiet == CW'(LIMIT));
endmodule

// File: rtl/plc_frame_tx.sv
`timescale 1ns/1ps
module plc_frame_tx
    import plc_frame_pkg::*;
#(
    parameter int CYC_PER_US  = 125,
    parameter int HALF_US     = 8333,
    parameter int PULSE_US    = 1000,
    parameter int WDOG_HALVES = 30,
    parameter int GAP_XINGS   = 6,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 8,
    parameter int REP_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [IDX_W-1:0] cmd_house,
    input  logic [IDX_W-1:0] cmd_key,
    input  logic [REP_W-1:0] cmd_reps,
    input  logic             zc_in,
    output logic             carrier_en,
    output logic             tx_done,
    output logic             tx_err
);
    localparam int PULSE_CYC = PULSE_US * CYC_PER_US;
    localparam int WDOG_CYC  = WDOG_HALVES * HALF_US * CYC_PER_US;
    localparam int GAP_CW    = $clog2(GAP_XINGS);
    localparam int SYM_CW    = $clog2(FRAME_LEN);

    tx_state_e state, state_nx;

    logic                 crossing, wd_expired, pulse_active, launch;
    logic                 fields_ok, last_sym, watched;
    logic [FRAME_LEN-1:0] frame_w, frame_q;
    logic [SYM_CW-1:0]    sym_idx;
    logic [GAP_CW-1:0]    gap_cnt;
    logic [REP_W-1:0]     reps_left;
    logic                 sym_q;

    plc_zc_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .zc_raw(zc_in), .crossing(crossing)
    );

    plc_frame_build u_build (
        .house(cmd_house[HOUSE_BITS-1:0]), .key(cmd_key[KEY_BITS-1:0]), .frame(frame_w)
    );

    plc_pulse_timer #(.WIDTH_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(launch), .active(pulse_active)
    );

    plc_watchdog #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .enable(watched), .kick(crossing), .expired(wd_expired)
    );

    assign fields_ok = (cmd_house < IDX_W'(1 << HOUSE_BITS)) && (cmd_key < IDX_W'(1 << KEY_BITS));
    assign last_sym  = (sym_idx == SYM_CW'(FRAME_LEN - 1));
    assign watched   = (state == ST_SYNC) || (state == ST_GAP) || (state == ST_SEND);
    assign launch    = (state == ST_SEND) && crossing && !wd_expired;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_valid)
                         state_nx = !fields_ok ? ST_FAIL : (cmd_reps == '0 ? ST_DONE : ST_SYNC);
            ST_SYNC: if (wd_expired)    state_nx = ST_FAIL;
                     else if (crossing) state_nx = ST_GAP;
            ST_GAP:  if (wd_expired)    state_nx = ST_FAIL;
                     else if (crossing && gap_cnt == GAP_CW'(GAP_XINGS - 2)) state_nx = ST_SEND;
            ST_SEND: if (wd_expired)    state_nx = ST_FAIL;
                     else if (crossing && last_sym && reps_left == REP_W'(1)) state_nx = ST_TAIL;
            ST_TAIL: if (!pulse_active) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            ST_FAIL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame, symbol and repeat counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            sym_idx   <= '0;
            gap_cnt   <= '0;
            reps_left <= '0;
            sym_q     <= 1'b0;
        end else if (state == ST_IDLE && cmd_valid) begin
            frame_q   <= frame_w;
            reps_left <= cmd_reps;
            sym_idx   <= '0;
            gap_cnt   <= '0;
        end else if (state == ST_GAP && crossing && !wd_expired) begin
            gap_cnt <= gap_cnt + 1'b1;
        end else if (launch) begin
            sym_q <= frame_q[SYM_CW'(FRAME_LEN - 1) - sym_idx];
            if (last_sym) begin
                sym_idx   <= '0;
                reps_left <= reps_left - 1'b1;
            end else begin
                sym_idx <= sym_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready  = (state == ST_IDLE);
        tx_done    = (state == ST_DONE);
        tx_err     = (state == ST_FAIL);
        carrier_en = ((state == ST_SEND) || (state == ST_TAIL)) && pulse_active && sym_q;
    end
endmodule

// File: rtl/plc_frame_tx_chk.sv
`timescale 1ns/1ps
module plc_frame_tx_chk #(
    parameter int PULSE_CYC = 125000,
    parameter int IDX_W     = 8,
    parameter int REP_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [IDX_W-1:0] cmd_house,
    input logic [IDX_W-1:0] cmd_key,
    input logic [REP_W-1:0] cmd_reps,
    input logic             carrier_en,
    input logic             tx_done,
    input logic             tx_err
);
    logic taken, bad_idx;
    int   run_len;

    assign taken   = cmd_valid && cmd_ready;
    assign bad_idx = (cmd_house >= IDX_W'(16)) || (cmd_key >= IDX_W'(32));

    always_ff @(posedge clk) begin
        if (!rst_n)          run_len <= 0;
        else if (carrier_en) run_len <= run_len + 1;
        else                 run_len <= 0;
    end

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !cmd_ready);

    // R2
    idle_no_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !carrier_en);

    // R3
    reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && bad_idx) |=> (tx_err && !carrier_en));

    // R4
    zero_reps_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !bad_idx && cmd_reps == '0) |=> tx_done);

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_en) |-> (run_len == PULSE_CYC));

    // R11
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_err));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (!tx_done && cmd_ready));

    // R12
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> (!tx_err && cmd_ready && !carrier_en));
endmodule

bind plc_frame_tx plc_frame_tx_chk #(
    .PULSE_CYC(PULSE_US * CYC_PER_US),
    .IDX_W(IDX_W),
    .REP_W(REP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_house(cmd_house), .cmd_key(cmd_key), .cmd_reps(cmd_reps),
    .carrier_en(carrier_en), .tx_done(tx_done), .tx_err(tx_err)
);

// File: tb/tb_plc_frame_tx.sv
`timescale 1ns/1ps
module tb_plc_frame_tx;
    localparam int CPU   = 1;
    localparam int HALF  = 40;
    localparam int PUL   = 10;
    localparam int WDH   = 3;
    localparam int GAPX  = 6;
    localparam int P     = PUL * CPU;
    localparam int LIMIT = WDH * HALF * CPU;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cmd_valid = 0;
    logic [7:0] cmd_house = 0, cmd_key = 0, cmd_reps = 0;
    logic       zc = 0;
    logic       zc_run = 0;
    logic       cmd_ready, carrier_en, tx_done, tx_err;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    plc_frame_tx #(.CYC_PER_US(CPU), .HALF_US(HALF), .PULSE_US(PUL),
                   .WDOG_HALVES(WDH), .GAP_XINGS(GAPX)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_house(cmd_house), .cmd_key(cmd_key), .cmd_reps(cmd_reps),
        .zc_in(zc), .carrier_en(carrier_en), .tx_done(tx_done), .tx_err(tx_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // zero-crossing wave: toggles every HALF*CPU cycles while running
    int hc = 0;
    always @(negedge clk) begin
        if (zc_run) begin
            if (hc == HALF*CPU - 1) begin hc <= 0; zc <= ~zc; end
            else hc <= hc + 1;
        end
    end

    // ---------- reference model ----------
    function automatic bit [3:0] house_code(input int h);
        case (h)
            0: return 4'b0110;   1: return 4'b1110;   2: return 4'b0010;   3: return 4'b1010;
            4: return 4'b0001;   5: return 4'b1001;   6: return 4'b0101;   7: return 4'b1101;
            8: return 4'b0111;   9: return 4'b1111;  10: return 4'b0011;  11: return 4'b1011;
           12: return 4'b0000;  13: return 4'b1000;  14: return 4'b0100;  default: return 4'b1100;
        endcase
    endfunction

    // symbol idx (0..21) of the frame for house h, key k (R7 R8 R9)
    function automatic bit frame_bit(input int h, input int k, input int idx);
        bit [3:0] hcode;
        bit [4:0] kcode;
        bit       v;
        hcode = house_code(h);
        kcode = (k < 16) ? {house_code(k), 1'b0} : {4'(k - 16), 1'b1};
        if (idx < 4) return (idx != 3);
        if (idx < 12) begin
            v = hcode[3 - (idx - 4) / 2];
            return ((idx - 4) % 2 == 0) ? v : !v;
        end
        v = kcode[4 - (idx - 12) / 2];
        return ((idx - 12) % 2 == 0) ? v : !v;
    endfunction

    int       cyc = 0;
    logic [3:0] zh;
    logic     val_s;
    int       hs, ks, rs;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) zh <= '0;
        else        zh <= {zh[2:0], zc};
        val_s <= cmd_valid;
        hs <= int'(cmd_house);
        ks <= int'(cmd_key);
        rs <= int'(cmd_reps);
    end

    int  m_mode, m_n, m_ref, m_total, m_pend_end, m_tail_end, m_h, m_k, m_idx;
    bit  m_psym, m_ready, m_done, m_err, m_prev_ready, m_xing, exp_car, car_prev;
    int  car_rises = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ready = 1; m_done = 0; m_err = 0;
            m_pend_end = 0; m_psym = 0; car_prev = 0;
        end else begin
            m_xing = (zh[2] != zh[3]);
            m_prev_ready = m_ready;
            m_done = 0;
            m_err  = 0;
            case (m_mode)
                0: if (m_prev_ready && val_s) begin
                       if (hs >= 16 || ks >= 32) m_err = 1;
                       else if (rs == 0)         m_done = 1;
                       else begin
                           m_mode = 1; m_n = -1; m_ref = cyc;
                           m_h = hs; m_k = ks; m_total = 22 * rs;
                       end
                   end
                1: if (cyc - m_ref == LIMIT + 1) begin
                       m_err = 1; m_mode = 0; m_pend_end = 0;
                   end else if (m_xing) begin
                       m_n++;
                       m_ref = cyc;
                       if (m_n >= GAPX) begin
                           m_idx = m_n - GAPX;
                           m_psym = frame_bit(m_h, m_k, m_idx % 22);
                           m_pend_end = cyc + P;
                           if (m_idx == m_total - 1) begin
                               m_mode = 2;
                               m_tail_end = cyc + P + 1;
                           end
                       end
                   end
                default: if (cyc == m_tail_end) begin m_done = 1; m_mode = 0; end
            endcase
            m_ready = (m_mode == 0) && !m_done && !m_err;
            exp_car = m_psym && (cyc < m_pend_end);

            check(carrier_en === exp_car, "R5 R6 R7 R8 R9 R10 R13 carrier", int'(carrier_en), int'(exp_car));
            check(tx_done === m_done, "R4 R11 tx_done", int'(tx_done), int'(m_done));
            check(tx_err === m_err, "R3 R12 tx_err", int'(tx_err), int'(m_err));
            check(cmd_ready === m_ready, "R1 R2 cmd_ready", int'(cmd_ready), int'(m_ready));

            if (carrier_en && !car_prev) car_rises++;
            car_prev = carrier_en;
        end
    end

    // ---------- stimulus ----------
    bit got_done, got_err;
    int base;

    task automatic send(input int h, input int k, input int r);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        base = car_rises;
        cmd_house = 8'(h); cmd_key = 8'(k); cmd_reps = 8'(r);
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_result();
        int n;
        got_done = 0; got_err = 0;
        for (n = 0; n < 20000; n++) begin
            if (tx_done || tx_err) break;
            @(negedge clk);
        end
        got_done = tx_done;
        got_err  = tx_err;
        @(negedge clk);
    endtask

    task automatic good_cmd(input int h, input int k, input int r, input string tag);
        send(h, k, r);
        wait_result();
        check(got_done && !got_err, {tag, " done seen"}, int'(got_done), 1);
        check(car_rises - base == 12 * r, {tag, " R7 pulses per command"}, car_rises - base, 12 * r);
        check(cmd_ready === 1'b1, {tag, " R2 ready after done"}, int'(cmd_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(carrier_en === 1'b0 && tx_done === 1'b0 && tx_err === 1'b0, "R1 outputs in reset", int'(carrier_en | tx_done | tx_err), 0);
        check(cmd_ready === 1'b1, "R1 ready in reset", int'(cmd_ready), 1);
        rst_n = 1;
        zc_run = 1;
        repeat (100) @(negedge clk);

        good_cmd(0, 0, 1, "R8 R9 unit key house A");
        good_cmd(15, 20, 2, "R9 R10 function key two copies");
        good_cmd(6, 15, 1, "R8 R9 unit 16 house G");
        good_cmd(12, 31, 3, "R10 R13 three copies");

        // R3 out-of-range refusals
        send(16, 3, 2);
        wait_result();
        check(got_err && !got_done, "R3 house 16 refused", int'(got_err), 1);
        check(car_rises == base, "R3 no carrier on refusal", car_rises - base, 0);
        send(2, 32, 1);
        wait_result();
        check(got_err && !got_done, "R3 key 32 refused", int'(got_err), 1);

        // R4 zero repeats
        send(5, 5, 0);
        wait_result();
        check(got_done && !got_err, "R4 zero repeats done", int'(got_done), 1);
        check(car_rises == base, "R4 no carrier", car_rises - base, 0);

        // R12 no crossings at all
        zc_run = 0;
        repeat (10) @(negedge clk);
        send(1, 1, 1);
        wait_result();
        check(got_err && !got_done, "R12 sync timeout", int'(got_err), 1);
        check(car_rises == base, "R12 no carrier without sync", car_rises - base, 0);

        // R12 crossings stop partway through a frame
        zc_run = 1;
        repeat (50) @(negedge clk);
        send(9, 24, 2);
        repeat (500) @(negedge clk);
        zc_run = 0;
        wait_result();
        check(got_err && !got_done, "R12 abort mid frame", int'(got_err), 1);
        check(carrier_en === 1'b0, "R12 carrier off after abort", int'(carrier_en), 0);

        // recovery after abort
        zc_run = 1;
        repeat (50) @(negedge clk);
        good_cmd(3, 18, 1, "R12 recovery");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule